// File: doc/BRIEF.md
# Memory-Card Slot Status and Interrupt Register Block

This block sits on a 32-bit word-addressed register bus beside a memory-card slot. It returns two fixed board words (an identification word and a decode word) and a status word that carries two card signals. The write-protect switch appears there as a live level. A card-insertion event is caught in a sticky bit, and that bit drives an interrupt line towards the system interrupt controller.

Software handles the interrupt by reading the status word, then writing it back with the insertion bit set, which clears the latch and drops the interrupt. Reads are combinational: read data follows the word address in the same cycle. A write takes effect at the rising clock edge where the write strobe is high.

Top module: `cdet_slot_ctrl`

## Requirements
- R1: Word address 0 reads the identification constant 0x41034003.
- R2: Word address 1 reads 0x00000000, and word address 3 reads the decode constant 0x00000011.
- R3: Bit 0 of the status word (word address 2) equals the present level of `wp_in` in the same cycle, with no latch.
- R4: When `card_in` is high at a rising edge, bit 3 of the status word is 1 from the next cycle on. It stays 1 after `card_in` falls, until it is cleared.
- R5: A write to word address 2 whose data has bit 3 set clears status bit 3 from the next cycle on. A write there with data bit 3 clear leaves bit 3 unchanged. Status bits other than 0 and 3 always read 0.
- R6: When `card_in` is high at the edge of a clearing write, status bit 3 stays 1 (the set wins).
- R7: `card_irq` equals status bit 3 in every cycle.
- R8: Writes to word addresses 0, 1, 3 or to any address of 4 or above change nothing. Reads of any address of 4 or above return 0.
- R9: While `rst_n` is low at a rising edge, the insertion latch is cleared, even when `card_in` is high. After reset, status bit 3 and `card_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Word address |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wp_in | input | 1 | Card write-protect level |
| card_in | input | 1 | Card-inserted level |
| card_irq | output | 1 | Insertion interrupt, high while the latch is set |

## Verification
The bench targets the edge where a clearing write and a high `card_in` meet. A design that gave the clear priority would show a one-cycle drop in bit 3, and a lost interrupt if `card_in` then fell. It drives clearing writes with data bit 3 low, and writes to the constant and unmapped words. A wrong decode would clear the latch from the wrong word or let write data alter a constant. Random `wp_in` toggles, checked against the same-cycle read, catch a design that registers write-protect and so reads one cycle stale. The bench also raises `card_in` during reset, which shows whether the latch gives reset priority.

// File: rtl/cdet_pkg.sv
// Shared constants for the card-slot status block.
// Assumes a 32-bit data path and word (not byte) addressing.
package cdet_pkg;
    localparam int          DATA_W      = 32;
    localparam logic [31:0] ID_WORD     = 32'h4103_4003;
    localparam logic [31:0] DECODE_WORD = 32'h0000_0011;
    localparam int          WP_BIT      = 0;
    localparam int          INS_BIT     = 3;

    typedef enum logic [1:0] {
        WORD_ID     = 2'd0,
        WORD_FLASH  = 2'd1,
        WORD_STATUS = 2'd2,
        WORD_DECODE = 2'd3
    } word_e;
endpackage

// File: rtl/cdet_addr_decode.sv
// Address decode for the four mapped words.
// Words 0..3 are mapped. Every address whose upper bits are nonzero is unmapped.
// Assumes ADDR_W >= 3.
module cdet_addr_decode #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              hit_id,
    output logic              hit_flash,
    output logic              hit_status,
    output logic              hit_decode,
    output logic              status_wr
);
    import cdet_pkg::*;

    localparam int UPPER_W = ADDR_W - 2;

    logic  mapped;
    word_e word;

    // Split the address into an in-range flag and a word selector.
    always_comb begin
        mapped = (addr[ADDR_W-1:2] == {UPPER_W{1'b0}});
        word   = word_e'(addr[1:0]);
    end

    // One select per mapped word.
    always_comb begin
        hit_id     = mapped && (word == WORD_ID);
        hit_flash  = mapped && (word == WORD_FLASH);
        hit_status = mapped && (word == WORD_STATUS);
        hit_decode = mapped && (word == WORD_DECODE);
    end

    // Only the status word takes writes; all other writes are dropped.
    always_comb status_wr = wr && hit_status;

    p_sel_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_id, hit_flash, hit_status, hit_decode}));
endmodule

// File: rtl/cdet_status_latch.sv
// Sticky card-insertion latch.
// A high card_in at an edge sets it. A clear request clears it, unless card_in
// is high at the same edge; set wins. Synchronous active-low reset has top priority.
module cdet_status_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic card_in,
    input  logic clr_req,
    output logic ins_q
);
    // Hold, set or clear the insertion flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ins_q <= 1'b0;
        else if (card_in)
            ins_q <= 1'b1;
        else if (clr_req)
            ins_q <= 1'b0;
    end

    p_set_on_insert_r4: assert property (@(posedge clk) disable iff (!rst_n)
        card_in |=> ins_q);
    p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (card_in && clr_req) |=> ins_q);
    p_clear_works_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !card_in) |=> !ins_q);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_in && !clr_req) |=> $stable(ins_q));
endmodule

// File: rtl/cdet_read_mux.sv
// Read-data selection.
// Assumes the word selects are one-hot or all zero. With no select high
// (an unmapped address) the output is zero.
module cdet_read_mux (
    input  logic                      hit_id,
    input  logic                      hit_flash,
    input  logic                      hit_status,
    input  logic                      hit_decode,
    input  logic                      wp_lvl,
    input  logic                      ins_q,
    output logic [cdet_pkg::DATA_W-1:0] rdata
);
    import cdet_pkg::*;

    logic [DATA_W-1:0] status_word;

    // Build the status word: live write-protect plus the sticky insertion bit.
    always_comb begin
        status_word          = '0;
        status_word[WP_BIT]  = wp_lvl;
        status_word[INS_BIT] = ins_q;
    end

    // OR the selected sources together; the flash word is always zero.
    always_comb begin
        rdata = ({DATA_W{hit_id}}     & ID_WORD)
              | ({DATA_W{hit_status}} & status_word)
              | ({DATA_W{hit_decode}} & DECODE_WORD)
              | ({DATA_W{hit_flash}}  & {DATA_W{1'b0}});
    end
endmodule

// File: rtl/cdet_slot_ctrl.sv
// Top level: card-slot status and interrupt register block.
// Reads are combinational from bus_addr. A write is taken at the rising edge
// while bus_wr is high. The interrupt is the insertion latch itself.
module cdet_slot_ctrl #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              wp_in,
    input  logic              card_in,
    output logic              card_irq
);
    import cdet_pkg::*;

    logic hit_id, hit_flash, hit_status, hit_decode, status_wr;
    logic clr_req, ins_q;

    cdet_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
        .hit_id(hit_id), .hit_flash(hit_flash), .hit_status(hit_status),
        .hit_decode(hit_decode), .status_wr(status_wr)
    );

    // Clear request: a status write with the insertion bit set in the data.
    always_comb clr_req = status_wr && bus_wdata[INS_BIT];

    cdet_status_latch u_latch (
        .clk(clk), .rst_n(rst_n), .card_in(card_in),
        .clr_req(clr_req), .ins_q(ins_q)
    );

    cdet_read_mux u_mux (
        .hit_id(hit_id), .hit_flash(hit_flash), .hit_status(hit_status),
        .hit_decode(hit_decode), .wp_lvl(wp_in), .ins_q(ins_q),
        .rdata(bus_rdata)
    );

    // The interrupt follows the sticky insertion bit.
    always_comb card_irq = ins_q;

    p_irq_matches_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_status |-> (card_irq == bus_rdata[INS_BIT]));
    p_wp_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_status |-> (bus_rdata[WP_BIT] == wp_in));
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= ADDR_W'(4)) |-> (bus_rdata == 32'h0));
    p_reset_clears_r9: assert property (@(posedge clk)
        !rst_n |=> !card_irq);
endmodule

// File: tb/tb_cdet_slot_ctrl.sv
module tb_cdet_slot_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wp_in = 1'b0;
    logic        card_in = 1'b0;
    logic        card_irq;

    int  n_run = 0;
    int  n_fail = 0;
    bit  exp_ins = 1'b0;
    bit  done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    cdet_slot_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wp_in(wp_in),
        .card_in(card_in), .card_irq(card_irq)
    );

    function automatic logic [31:0] exp_read(logic [7:0] a, bit wp, bit ins);
        case (a)
            8'd0:    return 32'h4103_4003;
            8'd1:    return 32'h0;
            8'd2:    return {28'h0, ins, 2'b00, wp};
            8'd3:    return 32'h11;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(logic [7:0] a);
        case (a)
            8'd0:    return "R1";
            8'd1:    return "R2";
            8'd2:    return "R3/R5";
            8'd3:    return "R2";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check before the rising edge, then update the model.
    task automatic cyc(logic [7:0] a, bit w, logic [31:0] d, bit wp, bit card);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = d; wp_in = wp; card_in = card;
        #5;
        chk(req_of(a), bus_rdata, exp_read(a, wp, exp_ins));
        chk("R7", {31'h0, card_irq}, {31'h0, exp_ins});
        @(posedge clk);
        if (card) exp_ins = 1'b1;
        else if (w && a == 8'd2 && d[3]) exp_ins = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R9: reset with card_in held high must leave the latch clear.
        card_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        card_in = 1'b0; rst_n = 1'b1; bus_addr = 8'd2;
        #5;
        chk("R9", bus_rdata, 32'h0);
        chk("R9", {31'h0, card_irq}, 32'h0);
        exp_ins = 1'b0;

        // R1, R2: constant words.
        cyc(8'd0, 0, 0, 0, 0);
        cyc(8'd1, 0, 0, 0, 0);
        cyc(8'd3, 0, 0, 0, 0);
        // R3: write-protect follows in the same cycle.
        cyc(8'd2, 0, 0, 1, 0);
        cyc(8'd2, 0, 0, 0, 0);
        // R4: insertion latches and stays after the input falls.
        cyc(8'd2, 0, 0, 0, 1);
        cyc(8'd2, 0, 0, 0, 0);
        cyc(8'd2, 0, 0, 1, 0);
        // R8: writes elsewhere with all ones change nothing.
        cyc(8'd0, 1, 32'hFFFF_FFFF, 0, 0);
        cyc(8'd1, 1, 32'hFFFF_FFFF, 0, 0);
        cyc(8'd3, 1, 32'hFFFF_FFFF, 0, 0);
        cyc(8'd6, 1, 32'hFFFF_FFFF, 0, 0);
        cyc(8'd2, 0, 0, 0, 0);
        // R5: a write with bit 3 low does not clear.
        cyc(8'd2, 1, 32'hFFFF_FFF7, 0, 0);
        cyc(8'd2, 0, 0, 0, 0);
        // R6: a clearing write while the card is still present.
        cyc(8'd2, 1, 32'h8, 0, 1);
        cyc(8'd2, 0, 0, 0, 0);
        // R5: a proper clear drops status and the interrupt.
        cyc(8'd2, 1, 32'h8, 1, 0);
        cyc(8'd2, 0, 0, 1, 0);
        // R8: unmapped reads.
        cyc(8'd4, 0, 0, 1, 0);
        cyc(8'd255, 0, 0, 1, 0);

        // Random mix, biased towards the status word.
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            bit w, wp, cd;
            a  = ($urandom % 3 == 0) ? 8'($urandom % 16) : 8'd2;
            w  = ($urandom % 4 == 0);
            d  = $urandom;
            wp = $urandom % 2;
            cd = ($urandom % 10 == 0);
            cyc(a, w, d, wp, cd);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule